// File: doc/BRIEF.md
# TDM Frame-Sync and Transmit Serializer

This block drives one time-division-multiplexed audio line. Every strobe on `bit_stb` marks one bit period. The block counts bit positions inside a slot and slots inside a frame. At the first bit of each slot that is not masked, it accepts one parallel word through a valid/ready handshake. It then shifts that word out one bit per strobe, with the most significant bit or the least significant bit first. The 24-bit input word may carry the sample left-justified at bit 23 or right-justified at bit 0.

In internal mode the block makes its own frame-sync pulse. The pulse lasts one bit or one slot. It can come on time or one bit period early, and it has either polarity. In external mode the block takes the active edge of `fs_in` as the start of a frame and holds `fs_out` at its inactive level. In a masked slot the data driver is released and no word is taken. If an unmasked slot opens with no word ready, the block sends zeros and flags an underrun.

All outputs are registered. They change only in the clock cycle that follows a strobe. The configuration inputs are static while the line runs.

Top module: `tdm_tx_framer`

## Requirements
- R1: After reset `sd_oe`, `sd_out`, `underrun` and `in_ready` are low and `fs_out` sits at its inactive level. In internal mode the first strobe produces a lead-in bit with `sd_oe` low, and the next strobe starts bit 0 of slot 0.
- R2: A frame holds `cfg_slots_m1`+1 slots, from 1 to 32. After the last bit of the last slot, the next strobe returns to bit 0 of slot 0.
- R3: `cfg_wlen` selects the word length and the slot length: 0 gives 8 bits, 1 gives 16, 2 gives 20 and 3 gives 24.
- R4: With `cfg_fs_word`=0, frame sync is active for one bit period. With `cfg_fs_word`=1, it is active for every bit period of slot 0.
- R5: With `cfg_fs_early`=1, the frame-sync window moves one bit period earlier, so it begins on the last bit of the previous frame (on the lead-in bit for the first frame).
- R6: With `cfg_fs_inv`=0, frame sync is active high on `fs_out` and `fs_in`. With `cfg_fs_inv`=1, it is active low on both.
- R7: With `cfg_lsb_first`=0, word bits go out from bit wl-1 down to bit 0. With `cfg_lsb_first`=1, they go out from bit 0 up to bit wl-1.
- R8: With `cfg_align_low`=1, the word is `in_data[wl-1:0]`. With `cfg_align_low`=0, the word is `in_data[23:24-wl]`.
- R9: When bit n of `slot_mask` is set, slot n drives `sd_oe` and `sd_out` low for the whole slot. The block takes no word in that slot, and slot counting still advances.
- R10: If an unmasked slot starts while `in_valid` is low, the slot sends zeros with `sd_oe` high, and `underrun` pulses high for exactly one cycle.
- R11: With `cfg_fs_ext`=1, the output stays idle until the first inactive-to-active change of `fs_in` seen at a strobe. When the change is seen, that strobe starts bit 0 of slot 0 if `cfg_fs_early`=0, or the next strobe does if `cfg_fs_early`=1. `fs_out` stays inactive in this mode.
- R12: `in_ready` is high only in a strobe cycle that starts an unmasked slot. `sd_oe` and `sd_out` change only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per bit period |
| cfg_slots_m1 | input | 5 | Slots per frame minus one |
| cfg_wlen | input | 2 | Word length code (8/16/20/24) |
| cfg_fs_word | input | 1 | 1: frame sync lasts a whole slot |
| cfg_fs_early | input | 1 | 1: frame sync one bit early |
| cfg_fs_inv | input | 1 | 1: frame sync active low |
| cfg_fs_ext | input | 1 | 1: frame start taken from fs_in |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_align_low | input | 1 | 1: word right-justified in in_data |
| slot_mask | input | 32 | Per-slot mask, set bit silences the slot |
| fs_in | input | 1 | External frame sync |
| in_data | input | 24 | Parallel word |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Word accepted at this edge when valid |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output-enable |
| fs_out | output | 1 | Generated frame sync |
| underrun | output | 1 | One-cycle pulse when a slot found no word |

## Verification
The assertions assume the configuration inputs never change while reset is released. The hold check on the serial outputs and the counter range checks rely on that. They also assume that strobes are at least one idle cycle apart and that the word length is at least 8, so an underrun can never follow another underrun in the next cycle. The stimulus changes configuration only while reset is held. It leaves one or two idle cycles between strobes, and in external mode it drives `fs_in` only with periodic pulses whose period matches the configured frame.

// File: rtl/tdm_tx_framer.sv
`timescale 1ns/1ps
module tdm_tx_framer #(
  parameter int SHW   = 24,
  parameter int MAXSL = 32,
  parameter int SLW   = $clog2(MAXSL),
  parameter int BW    = $clog2(SHW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic [SLW-1:0]   cfg_slots_m1,
  input  logic [1:0]       cfg_wlen,
  input  logic             cfg_fs_word,
  input  logic             cfg_fs_early,
  input  logic             cfg_fs_inv,
  input  logic             cfg_fs_ext,
  input  logic             cfg_lsb_first,
  input  logic             cfg_align_low,
  input  logic [MAXSL-1:0] slot_mask,
  input  logic             fs_in,
  input  logic [SHW-1:0]   in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             sd_out,
  output logic             sd_oe,
  output logic             fs_out,
  output logic             underrun
);
  logic run, pend, fs_prev, oe_q, fs_q, urun_q;
  logic [SLW-1:0] scnt, ns;
  logic [BW-1:0] bcnt, nb, wl, shamt;
  logic [SHW-1:0] sh, ld;
  logic fs_lvl, fs_edge, restart, pre, act, last_b, last_s, take, fs_n, slot_on;

  always_comb begin
    case (cfg_wlen)
      2'd0:    wl = BW'(8);
      2'd1:    wl = BW'(16);
      2'd2:    wl = BW'(20);
      default: wl = BW'(SHW);
    endcase
  end

  assign shamt   = BW'(SHW) - wl;
  assign fs_lvl  = fs_in ^ cfg_fs_inv;
  assign fs_edge = fs_lvl & ~fs_prev;
  assign restart = cfg_fs_ext & (cfg_fs_early ? pend : fs_edge);
  assign pre     = ~run & ~cfg_fs_ext;
  assign act     = run | restart;
  assign last_b  = bcnt == wl - 1'b1;
  assign last_s  = scnt == cfg_slots_m1;

  always_comb begin
    if (restart) begin
      ns = '0; nb = '0;
    end else if (pre) begin
      ns = cfg_slots_m1; nb = wl - 1'b1;
    end else if (last_b) begin
      nb = '0; ns = last_s ? '0 : scnt + 1'b1;
    end else begin
      nb = bcnt + 1'b1; ns = scnt;
    end
  end

  assign slot_on  = ~slot_mask[ns];
  assign in_ready = bit_stb & act & (nb == '0) & slot_on;
  assign take     = in_ready & in_valid;

  always_comb begin
    if (cfg_fs_ext)        fs_n = 1'b0;
    else if (pre)          fs_n = cfg_fs_early;
    else if (!act)         fs_n = 1'b0;
    else if (cfg_fs_early) fs_n = cfg_fs_word ? ((nb == wl - 1'b1) ? ns == cfg_slots_m1 : ns == '0)
                                              : (nb == wl - 1'b1) && (ns == cfg_slots_m1);
    else                   fs_n = (ns == '0) && (cfg_fs_word || nb == '0);
  end

  always_comb begin
    if (cfg_lsb_first) ld = cfg_align_low ? in_data : in_data >> shamt;
    else               ld = cfg_align_low ? in_data << shamt : in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; pend <= 1'b0; fs_prev <= 1'b0; oe_q <= 1'b0;
      fs_q <= 1'b0; urun_q <= 1'b0; scnt <= '0; bcnt <= '0; sh <= '0;
    end else begin
      urun_q <= 1'b0;
      if (bit_stb) begin
        fs_prev <= fs_lvl;
        pend    <= cfg_fs_ext & cfg_fs_early & fs_edge;
        fs_q    <= fs_n;
        oe_q    <= act & slot_on;
        if (pre | restart) run <= 1'b1;
        if (pre | act) begin
          scnt <= ns;
          bcnt <= nb;
        end
        if (!act) sh <= '0;
        else if (nb == '0) begin
          sh     <= take ? ld : '0;
          urun_q <= slot_on & ~in_valid;
        end else sh <= cfg_lsb_first ? sh >> 1 : sh << 1;
      end
    end
  end

  assign sd_out   = oe_q & (cfg_lsb_first ? sh[0] : sh[SHW-1]);
  assign sd_oe    = oe_q;
  assign fs_out   = fs_q ^ cfg_fs_inv;
  assign underrun = urun_q;

  assert_bit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n) bcnt < wl);
  assert_slot_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n) scnt <= cfg_slots_m1);
  assert_urun_single_R10: assert property (@(posedge clk) disable iff (!rst_n) underrun |=> !underrun);
  assert_urun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(bit_stb & ~in_valid));
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_stb) |-> ($stable(sd_oe) && $stable(sd_out)));
endmodule

// File: tb/tdm_tx_framer_tb.sv
`timescale 1ns/1ps
module tdm_tx_framer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0;
  logic [4:0] cfg_slots_m1 = '0;
  logic [1:0] cfg_wlen = '0;
  logic cfg_fs_word = 0, cfg_fs_early = 0, cfg_fs_inv = 0, cfg_fs_ext = 0;
  logic cfg_lsb_first = 0, cfg_align_low = 0, fs_in = 0, in_valid = 0;
  logic [31:0] slot_mask = '0;
  logic [23:0] in_data = '0;
  logic in_ready, sd_out, sd_oe, fs_out, underrun;

  tdm_tx_framer dut_i (.clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .cfg_slots_m1(cfg_slots_m1),
    .cfg_wlen(cfg_wlen), .cfg_fs_word(cfg_fs_word), .cfg_fs_early(cfg_fs_early),
    .cfg_fs_inv(cfg_fs_inv), .cfg_fs_ext(cfg_fs_ext), .cfg_lsb_first(cfg_lsb_first),
    .cfg_align_low(cfg_align_low), .slot_mask(slot_mask), .fs_in(fs_in), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .sd_out(sd_out), .sd_oe(sd_oe),
    .fs_out(fs_out), .underrun(underrun));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  logic [23:0] wq[$];
  int wl, fl, m_k, ext_len, ext_per;
  bit m_run, m_pend, m_prev, m_oe;
  logic [23:0] m_word;
  bit e_oe, e_sd, e_fs, e_ur;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] pick(input logic [23:0] d);
    if (cfg_align_low) return d & 24'((1 << wl) - 1);
    return d >> (24 - wl);
  endfunction

  task automatic step(input bit stb, input bit fsv);
    bit exp_ready = 0, take = 0, posv = 0, fe, rs;
    int sl, b;
    bit_stb  = stb;
    fs_in    = fsv ^ cfg_fs_inv;
    in_valid = wq.size() > 0;
    in_data  = (wq.size() > 0) ? wq[0] : 24'h0;
    e_ur = 0;
    if (stb) begin
      if (cfg_fs_ext) begin
        fe = fsv && !m_prev;
        rs = cfg_fs_early ? m_pend : fe;
        m_pend = cfg_fs_early && fe;
        m_prev = fsv;
        if (rs) begin m_run = 1; m_k = 0; posv = 1; end
        else if (m_run) begin m_k = (m_k + 1) % fl; posv = 1; end
        e_fs = 0;
      end else if (!m_run) begin
        m_run = 1; m_k = -1; e_fs = cfg_fs_early;
      end else begin
        m_k = (m_k + 1) % fl; posv = 1;
        if (cfg_fs_early) e_fs = cfg_fs_word ? (((m_k + 1) % fl) < wl) : (((m_k + 1) % fl) == 0);
        else              e_fs = cfg_fs_word ? (m_k < wl) : (m_k == 0);
      end
      if (posv) begin
        sl = m_k / wl; b = m_k % wl;
        if (b == 0) begin
          if (slot_mask[sl]) begin m_oe = 0; m_word = 0; end
          else begin
            m_oe = 1; exp_ready = 1;
            if (in_valid) begin take = 1; m_word = pick(wq[0]); end
            else begin m_word = 0; e_ur = 1; end
          end
        end
        e_oe = m_oe;
        e_sd = m_oe && (cfg_lsb_first ? m_word[b] : m_word[wl - 1 - b]);
      end else begin
        e_oe = 0; e_sd = 0;
      end
    end
    #1 chk("R12 in_ready", in_ready, exp_ready);
    @(posedge clk);
    if (take) void'(wq.pop_front());
    @(negedge clk);
    chk("R9/R10 sd_oe", sd_oe, e_oe);
    chk("R7/R8 sd_out", sd_out, e_sd);
    chk("R4/R5/R6 fs_out", fs_out, e_fs ^ cfg_fs_inv);
    chk("R10 underrun", underrun, e_ur);
  endtask

  task automatic setup(input int sm1, input int wc, input bit fw, input bit fe, input bit fi,
                       input bit fx, input bit lsb, input bit alow, input logic [31:0] msk, input int nw);
    rst_n = 0; bit_stb = 0; fs_in = fi;
    cfg_slots_m1 = 5'(sm1); cfg_wlen = 2'(wc); cfg_fs_word = fw; cfg_fs_early = fe;
    cfg_fs_inv = fi; cfg_fs_ext = fx; cfg_lsb_first = lsb; cfg_align_low = alow; slot_mask = msk;
    wl = (wc == 0) ? 8 : (wc == 1) ? 16 : (wc == 2) ? 20 : 24;
    fl = (sm1 + 1) * wl;
    m_run = 0; m_pend = 0; m_prev = 0; m_oe = 0; m_word = 0; m_k = 0;
    e_oe = 0; e_sd = 0; e_fs = 0; e_ur = 0; ext_len = 0; ext_per = fl;
    wq.delete();
    for (int i = 0; i < nw; i++) wq.push_back(24'h5A3C96 ^ 24'(i * 24'h0B1D27));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset sd_oe", sd_oe, 1'b0);
    chk("R1 reset sd_out", sd_out, 1'b0);
    chk("R1 reset underrun", underrun, 1'b0);
    chk("R1 reset fs_out", fs_out, fi);
    chk("R1 reset in_ready", in_ready, 1'b0);
  endtask

  task automatic run(input int nstb, input int gap);
    for (int i = 0; i < nstb; i++) begin
      bit f;
      f = (ext_len > 0) && (i >= 3) && (((i - 3) % ext_per) < ext_len);
      step(1, f);
      for (int g = 0; g < gap; g++) step(0, f);
    end
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL R12 watchdog got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R2 R3 R4: 4 slots of 8 bits, one-bit sync, MSB first, right-justified
    setup(3, 0, 0, 0, 0, 0, 0, 1, 32'h0, 12);
    run(4 * 8 * 2 + 3, 1);
    // R5 R6 R7 R8 R9: 3 slots of 16, word sync early, active low, LSB first, left-justified, slot 1 masked
    setup(2, 1, 1, 1, 1, 0, 1, 0, 32'h2, 8);
    run(3 * 16 * 2 + 2, 2);
    // R2 R5: single 24-bit slot, early one-bit sync
    setup(0, 3, 0, 1, 0, 0, 0, 0, 32'h0, 3);
    run(24 * 3 + 1, 1);
    // R10 R3: 20-bit slots, queue runs dry
    setup(1, 2, 1, 0, 0, 0, 1, 1, 32'h0, 2);
    run(20 * 4 + 1, 1);
    // R2 R9: 32 slots with a sparse mask
    setup(31, 0, 0, 0, 0, 0, 0, 1, 32'hA5A5_0F0F, 40);
    run(256 + 5, 1);
    // R11: external on-time one-bit sync
    setup(1, 0, 0, 0, 0, 1, 0, 1, 32'h0, 6);
    ext_len = 1;
    run(40, 1);
    // R11 R6: external early word-long sync, active low, LSB first
    setup(1, 0, 1, 1, 1, 1, 1, 1, 32'h0, 6);
    ext_len = 8;
    run(40, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule